// File: doc/BRIEF.md
# Presettable Synchronous Counter Cell

This cell is a small synchronous counter meant to be tiled into wider counters or used alone as a divider. One elaboration parameter chooses between a modulo-16 binary count and a modulo-10 decimal (BCD) count. A second parameter chooses whether the active-low clear acts at once or only on the next rising clock edge. A parallel data word can be preset through an active-low load strobe.

Counting needs two active-high enables at once: a parallel enable and a trickle enable. Only the trickle enable reaches the carry output, so a chain of cells can pass the trickle enable from each stage's carry to the next stage. At the same time, one common parallel enable starts and stops the whole chain without adding gating delay to the carry path.

A chip-level active-low reset clears the count asynchronously and is released through a two-flop synchronizer. The count therefore stays at zero for the first two rising edges after the reset is released.

Top module: `preset_count_cell`

## Requirements
- R1: While `rst_n` is low, `count` is 0000 and `carry` is low. The count stays at 0000 for the first two rising edges after `rst_n` rises.
- R2: With clear and load inactive (both high) and both enables high, a rising edge advances `count` by one. In binary mode 15 wraps to 0, so loading 12 and then counting gives 13, 14, 15, 0, 1, 2.
- R3: With clear and load inactive and either enable low, a rising edge leaves `count` unchanged.
- R4: With clear inactive and `load_n` low, a rising edge copies `din` into `count`, whatever the levels of the enables.
- R5: In synchronous-clear mode, a low `clr_n` at a rising edge sets `count` to 0000. This overrides load and both enables.
- R6: In asynchronous-clear mode, a low `clr_n` forces `count` to 0000 at once, with no clock edge needed, whatever the levels of load and the enables.
- R7: `carry` is high exactly when the trickle enable is high and `count` equals the last value of the cycle (15 in binary mode, 9 in decade mode). The parallel enable has no effect on it.
- R8: In decade mode, counting goes 9 to 0, so loading 7 and then counting gives 8, 9, 0, 1, 2, 3. A loaded value from 10 to 15 goes to 0 on the next counting edge, and `carry` stays low while the count holds such a value.
- R9: Changes on `load_n`, `en_par`, `en_trk` or `din` between clock edges leave `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous changes occur on its rising edge |
| rst_n | input | 1 | Chip reset, active low, asserted asynchronously and released synchronously |
| clr_n | input | 1 | Counter clear, active low; synchronous or asynchronous according to the parameter |
| load_n | input | 1 | Parallel preset strobe, active low |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, active high; also qualifies the carry |
| din | input | CNT_W | Preset value |
| count | output | CNT_W | Present count |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
Clear, load and counting can all be requested on the same edge, and load with both enables high is the case most likely to be mis-ordered. The random stimulus drives clear low about one cycle in sixteen and load low about one in six, while each enable is high most of the time, so these requests overlap often. Directed steps also put clear, load and both enables active together. A reference model applies clear first, then load, then counting, then hold, and the count is compared after every edge. In asynchronous mode the count is also compared just after clear falls and before any edge, which separates an immediate clear from one that waits for the clock.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic { CLR_SYNC = 1'b0, CLR_ASYNC = 1'b1 } clr_mode_e;
endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/pcc_next.sv
module pcc_next #(
  parameter int CNT_W   = 4,
  parameter int MODULUS = 16
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             sclr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] nxt,
  output logic             upd
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

  logic count_go;
  logic at_wrap;

  assign count_go = en_par & en_trk;
  assign at_wrap  = (cur >= LAST);

  // priority: clear, load, count, hold
  always_comb begin
    nxt = cur;
    upd = 1'b0;
    if (!sclr_n) begin
      nxt = '0;
      upd = 1'b1;
    end else if (!load_n) begin
      nxt = din;
      upd = 1'b1;
    end else if (count_go) begin
      nxt = at_wrap ? '0 : cur + CNT_W'(1);
      upd = 1'b1;
    end
  end
endmodule

// File: rtl/pcc_carry.sv
module pcc_carry #(
  parameter int CNT_W   = 4,
  parameter int MODULUS = 16
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             en_trk,
  output logic             carry
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

  assign carry = en_trk & (cur == LAST);
endmodule

// File: rtl/preset_count_cell.sv
module preset_count_cell
  import pcc_pkg::*;
#(
  parameter int        CNT_W    = 4,
  parameter int        MODULUS  = 16,
  parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] count,
  output logic             carry
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(MODULUS - 1);
  localparam bit               ASYNC = (CLR_MODE == CLR_ASYNC);

  logic             rst_q_n;
  logic             arst_n;
  logic             sclr_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_upd;

  pcc_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  generate
    if (ASYNC) begin : g_aclr
      assign arst_n = rst_q_n & clr_n;
      assign sclr_n = 1'b1;
    end else begin : g_sclr
      assign arst_n = rst_q_n;
      assign sclr_n = clr_n;
    end
  endgenerate

  pcc_next #(.CNT_W(CNT_W), .MODULUS(MODULUS)) u_next (
    .cur    (cnt_q),
    .sclr_n (sclr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .din    (din),
    .nxt    (cnt_d),
    .upd    (cnt_upd)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end

  pcc_carry #(.CNT_W(CNT_W), .MODULUS(MODULUS)) u_carry (
    .cur    (cnt_q),
    .en_trk (en_trk),
    .carry  (carry)
  );

  assign count = cnt_q;

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> (count == '0 && !carry));

  // R2 / R8: counting step with wrap
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && load_n && en_par && en_trk) |=>
      (count == (($past(count) >= LAST) ? '0 : $past(count) + CNT_W'(1))) || (ASYNC && count == '0));

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && load_n && !(en_par && en_trk)) |=> (count == $past(count)) || (ASYNC && count == '0));

  // R4
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && !load_n) |=> (count == $past(din)) || (ASYNC && count == '0));

  // R5
  a_r5_sync_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ASYNC && !clr_n) |=> count == '0);

  // R6
  a_r6_async_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ASYNC && !clr_n) |-> count == '0);

  // R7
  a_r7_carry_needs_trk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_trk |-> !carry);
  a_r7_carry_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> count == LAST);

  // R8: out-of-range value never raises carry
  a_r8_no_carry_over: assert property (@(posedge clk) disable iff (!rst_n)
    (count > LAST) |-> !carry);
endmodule

// File: tb/preset_count_cell_tb.sv
module preset_count_cell_tb;
  import pcc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_n, load_n, en_par, en_trk;
  logic [3:0] din;
  logic [3:0] qb, qd;
  logic       cb, cd;
  logic [3:0] mb, md;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #2 clk = ~clk;

  preset_count_cell u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_par(en_par), .en_trk(en_trk), .din(din), .count(qb), .carry(cb)
  );

  preset_count_cell #(.MODULUS(10), .CLR_MODE(CLR_ASYNC)) u_dut_dec (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_par(en_par), .en_trk(en_trk), .din(din), .count(qd), .carry(cd)
  );

  function automatic logic [3:0] ref_next(input logic [3:0] cur, input logic c, l, p, t,
                                          input logic [3:0] d, input logic [3:0] last);
    if (!c) return 4'd0;
    if (!l) return d;
    if (p && t) return (cur >= last) ? 4'd0 : cur + 4'd1;
    return cur;
  endfunction

  function automatic string step_tag(input logic c, l, p, t, input bit dec);
    if (!c) return dec ? "R6" : "R5";
    if (!l) return "R4";
    if (p && t) return dec ? "R8" : "R2";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic c, l, p, t, input logic [3:0] d);
    clr_n = c; load_n = l; en_par = p; en_trk = t; din = d;
    #1;
    if (!c) md = 4'd0;
    check("R9", qb, mb);
    check(c ? "R9" : "R6", qd, md);
    @(posedge clk);
    @(negedge clk);
    mb = ref_next(mb, c, l, p, t, d, 4'd15);
    md = ref_next(md, c, l, p, t, d, 4'd9);
    check(step_tag(c, l, p, t, 0), qb, mb);
    check(step_tag(c, l, p, t, 1), qd, md);
    check("R7", {3'b0, cb}, {3'b0, (t && mb == 4'd15)});
    check("R7", {3'b0, cd}, {3'b0, (t && md == 4'd9)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C7E));
    rst_n = 1'b0; clr_n = 1'b1; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1; din = 4'd0;
    mb = 4'd0; md = 4'd0;
    repeat (3) @(negedge clk);
    check("R1", qb, 4'd0); check("R1", qd, 4'd0);
    check("R1", {3'b0, cb}, 4'd0); check("R1", {3'b0, cd}, 4'd0);
    rst_n = 1'b1;
    // R1: enables high but synchronizer holds count at zero for two edges
    @(posedge clk); @(negedge clk);
    check("R1", qb, 4'd0); check("R1", qd, 4'd0);
    @(posedge clk); @(negedge clk);
    check("R1", qb, 4'd0); check("R1", qd, 4'd0);
    en_par = 1'b0; en_trk = 1'b0;
    @(posedge clk); @(negedge clk);
    mb = qb; md = qd;
    check("R1", qb, 4'd0);

    // R2 binary sequence from 12; R8 decade gets 12 (out of range) -> 0
    step(1, 0, 0, 0, 4'd12);
    check("R8", {3'b0, cd}, 4'd0);
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 4'd3);
    // R8 decade sequence from 7
    step(1, 0, 0, 0, 4'd7);
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 4'd0);
    // R7 carry at 15 with parallel enable low
    step(1, 0, 1, 1, 4'd15);
    step(1, 1, 0, 1, 4'd0);
    check("R7", {3'b0, cb}, 4'd1);
    step(1, 1, 1, 0, 4'd0);
    check("R7", {3'b0, cb}, 4'd0);
    // R4 load with enables low, R5/R6 clear beats load and count
    step(1, 0, 0, 0, 4'd9);
    step(0, 0, 1, 1, 4'd5);
    check("R5", qb, 4'd0);

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 16) != 0, ($urandom % 6) != 0, ($urandom % 4) != 0,
           ($urandom % 4) != 0, 4'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule